// File: doc/BRIEF.md
# Two-Cycle Fractional/Integer 8x8 Multiplier

This unit is the multiply engine of a small RISC core. A one-cycle start pulse captures two 8-bit operands, a sign selector, a fractional selector and the current status byte. The unit then spends two clock cycles on the arithmetic. In the first it forms two partial products from the operand nibbles, and in the second it adds them and applies the optional left shift. It presents a 16-bit result as a high byte and a low byte for a fixed register pair, together with a status byte in which only the zero and carry bits are rewritten, and a one-cycle done strobe.

Three sign treatments exist: both operands unsigned, both signed, and a signed first operand with an unsigned second. Each can run as a plain integer multiply or as a fractional multiply that doubles the product. The core's pipeline holds off while the unit is busy. The unit accepts a new start on the last cycle of a running multiply, so back-to-back operations issue every two cycles.

Top module: `mulUnit`

## Requirements
- R1: `signSel` picks the operand treatment: 0 treats both operands as unsigned, 1 treats both as two's complement, 2 treats `opA` as two's complement and `opB` as unsigned, and 3 behaves exactly like 0.
- R2: With `fracSel` low, `{prodHi,prodLo}` is the low 16 bits of the product of the operands as interpreted under R1.
- R3: With `fracSel` high, `{prodHi,prodLo}` is that 16-bit product shifted left by one bit with bit 15 dropped and bit 0 zero, and it never saturates (signed 0x80 by 0x80 gives 0x8000).
- R4: A start accepted at a rising edge raises `doneOut` in the cycle after the second following rising edge. Operands, selectors and `statusIn` are captured at the accepting edge. The results then hold until the next completion.
- R5: `doneOut` is high for exactly one cycle per accepted start.
- R6: `statusOut` bit 0 (carry) equals bit 15 of the 16-bit product before any fractional shift.
- R7: `statusOut` bit 1 (zero) is set exactly when the final 16-bit result is zero.
- R8: `statusOut` bits 7..2 equal the `statusIn` bits sampled with the accepted start.
- R9: A start presented on the first cycle after an accepted start is ignored. A start presented on the second cycle is accepted, so that back-to-back operations run every two cycles.
- R10: After reset, `prodHi`, `prodLo`, `statusOut`, `doneOut` and `busyOut` are all zero.
- R11: `busyOut` is high for the two cycles after an accepted start, and low when no operation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Start request, sampled each rising edge |
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand |
| signSel | input | 2 | Operand sign treatment (R1) |
| fracSel | input | 1 | Fractional (doubling) mode select |
| statusIn | input | 8 | Current status byte |
| prodHi | output | 8 | Result bits 15..8 |
| prodLo | output | 8 | Result bits 7..0 |
| statusOut | output | 8 | Status byte with zero and carry rewritten |
| doneOut | output | 1 | One-cycle completion strobe |
| busyOut | output | 1 | Operation in progress |

## Verification
The completion of one multiply and the acceptance of the next start can fall on the same clock edge. The final-add stage is then writing the old result while the operand latch captures new operands, selectors and status bits. The bench provokes this by issuing a second start in the last busy cycle of a first. It then expects the first result intact at its own done strobe, a quiet cycle after it, and the second result with its own preserved status bits two cycles later. A start on the first busy cycle is also issued, and the bench judges it by the absence of any extra done strobe and by outputs that stay unchanged.

// File: rtl/mulUnitPkg.sv
package mulUnitPkg;

  // strobes from control to datapath
  typedef struct packed {
    logic loadOps;   // capture operands, selectors and status
    logic stepMul;   // form partial products
    logic stepFin;   // sum, shift, flags, done
  } mulCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_FIN  = 2'd2
  } mulState_t;

  // sign selector codes
  localparam logic [1:0] SIGN_UU = 2'd0;
  localparam logic [1:0] SIGN_SS = 2'd1;
  localparam logic [1:0] SIGN_SU = 2'd2;

endpackage

// File: rtl/mulCtrl.sv
module mulCtrl
  import mulUnitPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startIn,
  output mulCtl_t ctl,
  output logic    busyOut
);

  mulState_t stateQ, stateD;

  always_comb begin
    ctl.loadOps = startIn && (stateQ != ST_MUL);
    ctl.stepMul = (stateQ == ST_MUL);
    ctl.stepFin = (stateQ == ST_FIN);
    case (stateQ)
      ST_IDLE: stateD = ST_IDLE;
      ST_MUL:  stateD = ST_FIN;
      ST_FIN:  stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
    if (ctl.loadOps) stateD = ST_MUL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busyOut = (stateQ != ST_IDLE);

endmodule

// File: rtl/mulPath.sv
module mulPath
  import mulUnitPkg::*;
#(
  parameter int OP_W   = 8,
  parameter int STAT_W = 8,
  parameter int Z_BIT  = 1,
  parameter int C_BIT  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  mulCtl_t           ctl,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  input  logic [1:0]        signSel,
  input  logic              fracSel,
  input  logic [STAT_W-1:0] statusIn,
  output logic [2*OP_W-1:0] prodOut,
  output logic [STAT_W-1:0] statusOut,
  output logic              doneOut
);

  localparam int PROD_W = 2 * OP_W;
  localparam int LO_W   = OP_W / 2;
  localparam int HI_W   = OP_W + 1 - LO_W;
  localparam int PP_W   = OP_W + 1 + HI_W;

  // operand stage
  logic signed [OP_W:0] aExtQ, bExtQ;
  logic                 fracQ;
  logic                 signA, signB;

  assign signA = (signSel == SIGN_SS) || (signSel == SIGN_SU);
  assign signB = (signSel == SIGN_SS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aExtQ <= '0;
      bExtQ <= '0;
      fracQ <= 1'b0;
    end else if (ctl.loadOps) begin
      aExtQ <= {signA & opA[OP_W-1], opA};
      bExtQ <= {signB & opB[OP_W-1], opB};
      fracQ <= fracSel;
    end
  end

  // partial product stage: low nibble of B unsigned, upper part signed
  logic signed [PP_W-1:0] aW, bLoW, bHiW;
  logic signed [PP_W-1:0] pp0Q, pp1Q;

  assign aW   = aExtQ;
  assign bLoW = $signed({1'b0, bExtQ[LO_W-1:0]});
  assign bHiW = $signed(bExtQ[OP_W:LO_W]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pp0Q <= '0;
      pp1Q <= '0;
    end else if (ctl.stepMul) begin
      pp0Q <= aW * bLoW;
      pp1Q <= aW * bHiW;
    end
  end

  // final stage: combine, optional doubling, flags
  logic signed [PROD_W-1:0] pp0W, pp1W, rawSum;
  logic [PROD_W-1:0]        resW;

  assign pp0W   = pp0Q;
  assign pp1W   = pp1Q;
  assign rawSum = pp0W + (pp1W <<< LO_W);
  assign resW   = fracQ ? {rawSum[PROD_W-2:0], 1'b0} : $unsigned(rawSum);

  logic zQ, cQ, doneQ;
  logic [PROD_W-1:0] prodQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prodQ <= '0;
      zQ    <= 1'b0;
      cQ    <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= ctl.stepFin;
      if (ctl.stepFin) begin
        prodQ <= resW;
        zQ    <= (resW == '0);
        cQ    <= rawSum[PROD_W-1];
      end
    end
  end

  // status byte: flag bits rewritten, the rest carried from the start
  for (genvar i = 0; i < STAT_W; i++) begin : gStat
    if (i == Z_BIT) begin : gZ
      assign statusOut[i] = zQ;
    end else if (i == C_BIT) begin : gC
      assign statusOut[i] = cQ;
    end else begin : gKeep
      logic holdQ, outQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          holdQ <= 1'b0;
          outQ  <= 1'b0;
        end else begin
          if (ctl.loadOps) holdQ <= statusIn[i];
          if (ctl.stepFin) outQ  <= holdQ;
        end
      end
      assign statusOut[i] = outQ;
    end
  end

  assign prodOut = prodQ;
  assign doneOut = doneQ;

endmodule

// File: rtl/mulUnit.sv
module mulUnit
  import mulUnitPkg::*;
#(
  parameter int OP_W   = 8,
  parameter int STAT_W = 8,
  parameter int Z_BIT  = 1,
  parameter int C_BIT  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  input  logic [1:0]        signSel,
  input  logic              fracSel,
  input  logic [STAT_W-1:0] statusIn,
  output logic [OP_W-1:0]   prodHi,
  output logic [OP_W-1:0]   prodLo,
  output logic [STAT_W-1:0] statusOut,
  output logic              doneOut,
  output logic              busyOut
);

  mulCtl_t ctl;
  logic [2*OP_W-1:0] prodW;
  logic loadStrobe;

  mulCtrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .ctl     (ctl),
    .busyOut (busyOut)
  );

  mulPath #(
    .OP_W   (OP_W),
    .STAT_W (STAT_W),
    .Z_BIT  (Z_BIT),
    .C_BIT  (C_BIT)
  ) path_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .opA       (opA),
    .opB       (opB),
    .signSel   (signSel),
    .fracSel   (fracSel),
    .statusIn  (statusIn),
    .prodOut   (prodW),
    .statusOut (statusOut),
    .doneOut   (doneOut)
  );

  assign loadStrobe = ctl.loadOps;
  assign prodHi = prodW[2*OP_W-1:OP_W];
  assign prodLo = prodW[OP_W-1:0];

endmodule

// File: rtl/mulUnitChk.sv
module mulUnitChk #(
  parameter int OP_W   = 8,
  parameter int STAT_W = 8,
  parameter int Z_BIT  = 1,
  parameter int C_BIT  = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              fracSel,
  input logic [STAT_W-1:0] statusIn,
  input logic [OP_W-1:0]   prodHi,
  input logic [OP_W-1:0]   prodLo,
  input logic [STAT_W-1:0] statusOut,
  input logic              doneOut,
  input logic              busyOut,
  input logic              loadStrobe
);

  localparam logic [STAT_W-1:0] KEEP_MASK =
    ~((STAT_W'(1) << Z_BIT) | (STAT_W'(1) << C_BIT));

  AST_LOAD_TO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |-> ##3 doneOut);  // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);  // R5

  AST_BUSY_TWO: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |=> busyOut ##1 busyOut);  // R11

  AST_IGNORE_EARLY: assert property (@(posedge clk) disable iff (!rstN)
    $past(loadStrobe) |-> !loadStrobe);  // R9

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (statusOut[Z_BIT] == ({prodHi, prodLo} == '0)));  // R7

  AST_FRAC_LSB: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && $past(loadStrobe, 3) && $past(fracSel, 3)) |-> !prodLo[0]);  // R3

  AST_KEEP_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && $past(loadStrobe, 3)) |->
      ((statusOut & KEEP_MASK) == ($past(statusIn, 3) & KEEP_MASK)));  // R8

endmodule

bind mulUnit mulUnitChk #(
  .OP_W   (OP_W),
  .STAT_W (STAT_W),
  .Z_BIT  (Z_BIT),
  .C_BIT  (C_BIT)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .fracSel    (fracSel),
  .statusIn   (statusIn),
  .prodHi     (prodHi),
  .prodLo     (prodLo),
  .statusOut  (statusOut),
  .doneOut    (doneOut),
  .busyOut    (busyOut),
  .loadStrobe (loadStrobe)
);

// File: tb/mulUnit_tb_top.sv
module mulUnit_tb_top;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startIn = 1'b0;
  logic [7:0] opA = '0, opB = '0;
  logic [1:0] signSel = '0;
  logic       fracSel = 1'b0;
  logic [7:0] statusIn = '0;
  logic [7:0] prodHi, prodLo, statusOut;
  logic       doneOut, busyOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mulUnit dut_i (
    .clk(clk), .rstN(rstN), .startIn(startIn), .opA(opA), .opB(opB),
    .signSel(signSel), .fracSel(fracSel), .statusIn(statusIn),
    .prodHi(prodHi), .prodLo(prodLo), .statusOut(statusOut),
    .doneOut(doneOut), .busyOut(busyOut)
  );

  // ---------------- reference model ----------------
  function automatic logic [15:0] rawProd(logic [7:0] a, logic [7:0] b, logic [1:0] s);
    int av, bv, p;
    av = (s == 2'd1 || s == 2'd2) ? int'($signed(a)) : int'(a);
    bv = (s == 2'd1) ? int'($signed(b)) : int'(b);
    p  = av * bv;
    return p[15:0];
  endfunction

  function automatic logic [15:0] refRes(logic [7:0] a, logic [7:0] b, logic [1:0] s, logic f);
    logic [15:0] r;
    r = rawProd(a, b, s);
    return f ? {r[14:0], 1'b0} : r;
  endfunction

  function automatic logic [7:0] refStat(logic [7:0] a, logic [7:0] b, logic [1:0] s,
                                         logic f, logic [7:0] st);
    logic [15:0] r;
    r = rawProd(a, b, s);
    return {st[7:2], (refRes(a, b, s, f) == 16'h0), r[15]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [7:0] a, logic [7:0] b, logic [1:0] s, logic f, logic [7:0] st);
    startIn = 1'b1; opA = a; opB = b; signSel = s; fracSel = f; statusIn = st;
  endtask

  task automatic scramble();
    startIn = 1'b0;
    opA = 8'($urandom); opB = 8'($urandom);
    signSel = 2'($urandom); fracSel = 1'($urandom); statusIn = 8'($urandom);
  endtask

  // single operation; called right after a falling edge
  task automatic runOne(string req, logic [7:0] a, logic [7:0] b, logic [1:0] s,
                        logic f, logic [7:0] st);
    logic [15:0] er;
    logic [7:0]  es;
    er = refRes(a, b, s, f);
    es = refStat(a, b, s, f, st);
    drive(a, b, s, f, st);
    @(negedge clk); scramble();
    @(negedge clk);
    @(negedge clk);
    check({req, " done"}, 32'(doneOut), 32'd1);
    check({req, " product"}, 32'({prodHi, prodLo}), 32'(er));
    check({req, " status R6 R7 R8"}, 32'(statusOut), 32'(es));
    @(negedge clk);
    check("R5 done single cycle", 32'(doneOut), 32'd0);
    check("R4 result holds", 32'({prodHi, prodLo}), 32'(er));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [15:0] erA, erB;
    logic [7:0]  esA, esB;
    seed = $urandom(32'h1F2E3D4C);

    // R10 reset state
    repeat (3) @(negedge clk);
    check("R10 prod", 32'({prodHi, prodLo}), 32'd0);
    check("R10 status", 32'(statusOut), 32'd0);
    check("R10 done", 32'(doneOut), 32'd0);
    check("R10 busy", 32'(busyOut), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // directed corners
    runOne("R2 unsigned max", 8'hFF, 8'hFF, 2'd0, 1'b0, 8'hA4);
    runOne("R3 unsigned frac max", 8'hFF, 8'hFF, 2'd0, 1'b1, 8'h5B);
    runOne("R2 signed -1*-1", 8'hFF, 8'hFF, 2'd1, 1'b0, 8'hFF);
    runOne("R1 mixed -1*255", 8'hFF, 8'hFF, 2'd2, 1'b0, 8'h00);
    runOne("R3 signed 0x80*0x80 wraps", 8'h80, 8'h80, 2'd1, 1'b1, 8'hC3);
    runOne("R1 code3 as unsigned", 8'h81, 8'hC7, 2'd3, 1'b0, 8'h3C);
    runOne("R7 zero product", 8'h00, 8'h9A, 2'd1, 1'b1, 8'hFF);
    runOne("R6 signed negative", 8'h7F, 8'h80, 2'd1, 1'b0, 8'h12);
    runOne("R1 mixed pos*high", 8'h7F, 8'hF0, 2'd2, 1'b1, 8'h81);

    // R9 start on first busy cycle is ignored; R11 busy window
    erA = refRes(8'h23, 8'h45, 2'd0, 1'b0);
    drive(8'h23, 8'h45, 2'd0, 1'b0, 8'hF0);
    @(negedge clk);
    check("R11 busy cycle 1", 32'(busyOut), 32'd1);
    drive(8'hEE, 8'hDD, 2'd1, 1'b1, 8'h0F);
    @(negedge clk); scramble(); startIn = 1'b0;
    check("R11 busy cycle 2", 32'(busyOut), 32'd1);
    @(negedge clk);
    check("R9 first done", 32'(doneOut), 32'd1);
    check("R9 first product", 32'({prodHi, prodLo}), 32'(erA));
    check("R11 busy drops", 32'(busyOut), 32'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9 no extra done", 32'(doneOut), 32'd0);
      check("R9 product unchanged", 32'({prodHi, prodLo}), 32'(erA));
    end

    // R9 back-to-back: start in final busy cycle
    erA = refRes(8'h9C, 8'h37, 2'd2, 1'b1);
    esA = refStat(8'h9C, 8'h37, 2'd2, 1'b1, 8'hAA);
    erB = refRes(8'hC8, 8'hB1, 2'd1, 1'b0);
    esB = refStat(8'hC8, 8'hB1, 2'd1, 1'b0, 8'h55);
    drive(8'h9C, 8'h37, 2'd2, 1'b1, 8'hAA);
    @(negedge clk); scramble();
    @(negedge clk); drive(8'hC8, 8'hB1, 2'd1, 1'b0, 8'h55);
    @(negedge clk); scramble();
    check("R9 b2b first done", 32'(doneOut), 32'd1);
    check("R9 b2b first product", 32'({prodHi, prodLo}), 32'(erA));
    check("R8 b2b first status", 32'(statusOut), 32'(esA));
    check("R11 b2b busy", 32'(busyOut), 32'd1);
    @(negedge clk);
    check("R5 b2b gap", 32'(doneOut), 32'd0);
    @(negedge clk);
    check("R9 b2b second done", 32'(doneOut), 32'd1);
    check("R9 b2b second product", 32'({prodHi, prodLo}), 32'(erB));
    check("R8 b2b second status", 32'(statusOut), 32'(esB));
    @(negedge clk);

    // random mix over all modes
    for (int n = 0; n < 150; n++) begin
      runOne("R2 R3 random", 8'($urandom), 8'($urandom), 2'($urandom),
             1'($urandom), 8'($urandom));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule